// File: doc/BRIEF.md
# Data-Hazard Bypass and Interlock Unit

This block resolves read-after-write hazards for a five-stage in-order pipeline with fetch, decode (ID), execute (EX), memory access (MA) and write-back (WB) stages. Each cycle it compares the source register indices of the instruction in ID with the destination indices of the three older instructions in EX, MA and WB. From that comparison it derives three things. The first is the bypass select that the ALU operand multiplexers use once the ID instruction has moved into EX. The second is a same-cycle pass-through flag that lets the ID read path take the value being written back. The third is a hold request for load-use pairs.

Results produced by the ALU reach a dependent instruction with no lost cycle. A load that feeds the very next instruction holds PC and the fetch/decode register for one cycle and places a NOP into EX. The instruction is then served from the MA/WB bypass path. Older instructions keep advancing while the younger ones are held. The select for the EX-stage instruction is registered, so the block drives the EX multiplexers straight from flops.

Top module: `hazard_ctl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, both operand selects read 00 (register file).
- R2: Each operand select is 2 bits. Operand A uses `fwd_sel_o[1:0]` and operand B uses `fwd_sel_o[3:2]`. The codes are 00 for the register file, 01 for the MA/WB value and 10 for the EX/MA value; 11 is never produced. If a used source matches the destination of a writing non-load in EX, the select for that operand reads 10 one cycle later and no stall is raised.
- R3: If a used source matches a writing instruction in MA and does not match a writing instruction in EX, the select reads 01 one cycle later.
- R4: If a used source matches a writing instruction in WB and matches no writing instruction in EX or MA, the operand's `wb_pass_o` bit (bit 0 for A, bit 1 for B) is high in that same cycle and the select reads 00 one cycle later.
- R5: The newest producer wins: EX over MA over WB. For each operand, at most one of {EX bypass, MA bypass, WB pass, load-use} applies.
- R6: If a used source matches a writing load in EX, `stall_o` and `bubble_o` are both high in that same cycle. In the next cycle both selects read 00, because EX then holds the NOP. This applies even when the other operand has a bypass match.
- R7: After a one-cycle load-use hold, the held instruction sees the load in MA and gets select 01 with no further stall.
- R8: Source index 0 never causes a bypass, a pass-through or a stall.
- R9: A source whose use bit is low (`id_use_i` bit 0 for A, bit 1 for B) never causes a hazard. A producer whose write-enable is low never causes a hazard either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| id_src_i | input | 10 | ID source indices; A in [4:0], B in [9:5] |
| id_use_i | input | 2 | Source-valid bits; bit 0 A, bit 1 B |
| ex_rd_i | input | 5 | Destination index of the EX instruction |
| ex_we_i | input | 1 | EX instruction writes a register |
| ex_load_i | input | 1 | EX instruction is a load |
| ma_rd_i | input | 5 | Destination index of the MA instruction |
| ma_we_i | input | 1 | MA instruction writes a register |
| wb_rd_i | input | 5 | Destination index of the WB instruction |
| wb_we_i | input | 1 | WB instruction writes a register |
| stall_o | output | 1 | Hold PC and the fetch/decode register |
| bubble_o | output | 1 | Place a NOP into EX on the next edge |
| fwd_sel_o | output | 4 | Registered ALU operand selects for the EX instruction |
| wb_pass_o | output | 2 | Same-cycle write-back pass-through for the ID read, per operand |

## Verification
A load-use hold on one operand can coincide with a bypass match on the other operand, or with a write-back pass-through on it. The stimulus table provokes this directly: operand B depends on a load in EX while operand A matches the producer in MA, and in a second row operand B matches WB while A depends on the load. The bench judges that the hold wins: the stall appears in the same cycle, and both selects read 00 on the following cycle. It also checks that the pass-through flag still reports the write-back match. A directed two-cycle sequence then confirms that the held instruction picks up the MA/WB path once the bubble has moved on.

// File: rtl/hazard_pkg.sv
package hazard_pkg;

    // Operand source codes for the EX-stage ALU multiplexers
    typedef enum logic [1:0] {
        SEL_REGFILE = 2'b00,
        SEL_LATE    = 2'b01,   // MA/WB pipeline register value
        SEL_EARLY   = 2'b10    // EX/MA pipeline register value
    } opnd_sel_e;

    // Prioritised comparison result for one source operand
    typedef struct packed {
        logic from_ex;
        logic from_ma;
        logic from_wb;
        logic load_use;
    } src_hit_t;

endpackage

// File: rtl/hazard_src_cmp.sv
module hazard_src_cmp
    import hazard_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [REG_W-1:0] src_i,
    input  logic             use_i,
    input  logic [REG_W-1:0] ex_rd_i,
    input  logic             ex_we_i,
    input  logic             ex_load_i,
    input  logic [REG_W-1:0] ma_rd_i,
    input  logic             ma_we_i,
    input  logic [REG_W-1:0] wb_rd_i,
    input  logic             wb_we_i,
    output src_hit_t         hit_o
);

    logic live;
    logic m_ex, m_ma, m_wb;

    always_comb begin
        live  = use_i && (src_i != '0);
        m_ex  = live && ex_we_i && (ex_rd_i == src_i);
        m_ma  = live && ma_we_i && (ma_rd_i == src_i);
        m_wb  = live && wb_we_i && (wb_rd_i == src_i);

        hit_o          = '0;
        hit_o.load_use = m_ex && ex_load_i;
        hit_o.from_ex  = m_ex && !ex_load_i;
        hit_o.from_ma  = !m_ex && m_ma;
        hit_o.from_wb  = !m_ex && !m_ma && m_wb;
    end

    // R5
    one_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({hit_o.from_ex, hit_o.from_ma, hit_o.from_wb, hit_o.load_use}));

    // R8
    zero_reg_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_i == '0) |-> (hit_o == '0));

    // R9
    unused_src_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !use_i |-> (hit_o == '0));

endmodule

// File: rtl/hazard_sel_reg.sv
module hazard_sel_reg
    import hazard_pkg::*;
#(
    parameter int NSRC = 2
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  bubble_i,
    input  src_hit_t [NSRC-1:0]   hits_i,
    output logic [2*NSRC-1:0]     sel_o
);

    typedef struct packed {
        logic [2*NSRC-1:0] sel;
    } sel_state_t;

    sel_state_t st_d, st_q;

    always_comb begin
        st_d = '0;
        if (!bubble_i) begin
            for (int k = 0; k < NSRC; k++) begin
                if (hits_i[k].from_ex)
                    st_d.sel[2*k +: 2] = SEL_EARLY;
                else if (hits_i[k].from_ma)
                    st_d.sel[2*k +: 2] = SEL_LATE;
                else
                    st_d.sel[2*k +: 2] = SEL_REGFILE;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign sel_o = st_q.sel;

    // R6
    bubble_clears_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bubble_i |=> (sel_o == '0));

    // R2
    no_code_three_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sel_o[1:0] != 2'b11);

endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import hazard_pkg::*;
#(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NSRC*REG_W-1:0]   id_src_i,
    input  logic [NSRC-1:0]         id_use_i,
    input  logic [REG_W-1:0]        ex_rd_i,
    input  logic                    ex_we_i,
    input  logic                    ex_load_i,
    input  logic [REG_W-1:0]        ma_rd_i,
    input  logic                    ma_we_i,
    input  logic [REG_W-1:0]        wb_rd_i,
    input  logic                    wb_we_i,
    output logic                    stall_o,
    output logic                    bubble_o,
    output logic [2*NSRC-1:0]       fwd_sel_o,
    output logic [NSRC-1:0]         wb_pass_o
);

    src_hit_t [NSRC-1:0] hits;
    logic     [NSRC-1:0] lu_vec;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        hazard_src_cmp #(.REG_W(REG_W)) cmp_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .src_i     (id_src_i[g*REG_W +: REG_W]),
            .use_i     (id_use_i[g]),
            .ex_rd_i   (ex_rd_i),
            .ex_we_i   (ex_we_i),
            .ex_load_i (ex_load_i),
            .ma_rd_i   (ma_rd_i),
            .ma_we_i   (ma_we_i),
            .wb_rd_i   (wb_rd_i),
            .wb_we_i   (wb_we_i),
            .hit_o     (hits[g])
        );
        assign lu_vec[g]    = hits[g].load_use;
        assign wb_pass_o[g] = hits[g].from_wb;
    end

    // Hold younger instructions and inject a NOP into EX together
    assign stall_o  = |lu_vec;
    assign bubble_o = stall_o;

    hazard_sel_reg #(.NSRC(NSRC)) sel_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .bubble_i (bubble_o),
        .hits_i   (hits),
        .sel_o    (fwd_sel_o)
    );

    // R2
    alu_chain_no_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_use_i[0] && ex_we_i && !ex_load_i && (ex_rd_i != '0)
         && (ex_rd_i == id_src_i[REG_W-1:0]) && !stall_o)
        |=> (fwd_sel_o[1:0] == 2'b10));

    // R6
    load_use_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (id_use_i[0] && ex_we_i && ex_load_i && (ex_rd_i != '0)
         && (ex_rd_i == id_src_i[REG_W-1:0])) |-> stall_o);

endmodule

// File: tb/hazard_ctl_tb_top.sv
module hazard_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [9:0]  id_src;
    logic [1:0]  id_use;
    logic [4:0]  ex_rd, ma_rd, wb_rd;
    logic        ex_we, ex_ld, ma_we, wb_we;
    logic        stall, bubble;
    logic [3:0]  fwd_sel;
    logic [1:0]  wb_pass;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    hazard_ctl #(.REG_W(5), .NSRC(2)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .id_src_i(id_src), .id_use_i(id_use),
        .ex_rd_i(ex_rd), .ex_we_i(ex_we), .ex_load_i(ex_ld),
        .ma_rd_i(ma_rd), .ma_we_i(ma_we),
        .wb_rd_i(wb_rd), .wb_we_i(wb_we),
        .stall_o(stall), .bubble_o(bubble),
        .fwd_sel_o(fwd_sel), .wb_pass_o(wb_pass)
    );

    typedef struct packed {
        logic [4:0] sa;  logic [4:0] sb;  logic [1:0] use_;
        logic [4:0] exrd; logic exwe; logic exld;
        logic [4:0] mard; logic mawe;
        logic [4:0] wbrd; logic wbwe;
        logic       x_stall; logic [1:0] x_wbp; logic [3:0] x_sel;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VEC [NV] = '{
        '{5'd3,  5'd4,  2'b11, 5'd3,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 2'b00, 4'b0010, 4'd2}, // R2 A
        '{5'd5,  5'd6,  2'b11, 5'd6,  1'b1, 1'b0, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 2'b00, 4'b1000, 4'd2}, // R2 B
        '{5'd7,  5'd8,  2'b11, 5'd0,  1'b0, 1'b0, 5'd7,  1'b1, 5'd0,  1'b0, 1'b0, 2'b00, 4'b0001, 4'd3}, // R3
        '{5'd9,  5'd10, 2'b11, 5'd0,  1'b0, 1'b0, 5'd0,  1'b0, 5'd10, 1'b1, 1'b0, 2'b10, 4'b0000, 4'd4}, // R4
        '{5'd11, 5'd11, 2'b11, 5'd11, 1'b1, 1'b0, 5'd11, 1'b1, 5'd11, 1'b1, 1'b0, 2'b00, 4'b1010, 4'd5}, // R5
        '{5'd12, 5'd13, 2'b11, 5'd13, 1'b1, 1'b0, 5'd12, 1'b1, 5'd12, 1'b1, 1'b0, 2'b00, 4'b1001, 4'd5}, // R5 mixed
        '{5'd14, 5'd2,  2'b11, 5'd14, 1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b1, 2'b00, 4'b0000, 4'd6}, // R6
        '{5'd1,  5'd15, 2'b11, 5'd15, 1'b1, 1'b1, 5'd1,  1'b1, 5'd0,  1'b0, 1'b1, 2'b00, 4'b0000, 4'd6}, // R6 with bypass on A
        '{5'd0,  5'd0,  2'b11, 5'd0,  1'b1, 1'b1, 5'd0,  1'b1, 5'd0,  1'b1, 1'b0, 2'b00, 4'b0000, 4'd8}, // R8
        '{5'd3,  5'd3,  2'b00, 5'd3,  1'b1, 1'b1, 5'd3,  1'b1, 5'd3,  1'b1, 1'b0, 2'b00, 4'b0000, 4'd9}, // R9 use low
        '{5'd4,  5'd5,  2'b11, 5'd4,  1'b0, 1'b1, 5'd5,  1'b0, 5'd4,  1'b0, 1'b0, 2'b00, 4'b0000, 4'd9}, // R9 we low
        '{5'd6,  5'd7,  2'b10, 5'd6,  1'b1, 1'b1, 5'd0,  1'b0, 5'd0,  1'b0, 1'b0, 2'b00, 4'b0000, 4'd9}, // R9 A unused
        '{5'd20, 5'd21, 2'b11, 5'd20, 1'b1, 1'b1, 5'd0,  1'b0, 5'd21, 1'b1, 1'b1, 2'b10, 4'b0000, 4'd6}  // R6 with R4 on B
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        id_src = {v.sb, v.sa}; id_use = v.use_;
        ex_rd = v.exrd; ex_we = v.exwe; ex_ld = v.exld;
        ma_rd = v.mard; ma_we = v.mawe;
        wb_rd = v.wbrd; wb_we = v.wbwe;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        // R1: a bypass-looking input during reset must not reach the selects
        drive(VEC[0]);
        repeat (2) @(posedge clk);
        #1 check("R1 sel in reset", {4'b0, fwd_sel}, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;
        drive('0);
        @(posedge clk);
        #1 check("R1 sel after reset", {4'b0, fwd_sel}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(VEC[i]);
            #1;
            check($sformatf("R%0d row %0d stall", VEC[i].req, i), {7'b0, stall}, {7'b0, VEC[i].x_stall});
            check($sformatf("R%0d row %0d bubble", VEC[i].req, i), {7'b0, bubble}, {7'b0, VEC[i].x_stall});
            check($sformatf("R%0d row %0d wb_pass", VEC[i].req, i), {6'b0, wb_pass}, {6'b0, VEC[i].x_wbp});
            @(posedge clk);
            #1 check($sformatf("R%0d row %0d sel", VEC[i].req, i), {4'b0, fwd_sel}, {4'b0, VEC[i].x_sel});
        end

        // R7: load r9 in EX feeding operand A, then the load in MA with a bubble in EX
        @(negedge clk);
        drive('0);
        id_src = {5'd0, 5'd9}; id_use = 2'b01;
        ex_rd = 5'd9; ex_we = 1'b1; ex_ld = 1'b1;
        #1 check("R7 first cycle stall", {7'b0, stall}, 8'h01);
        @(negedge clk);
        ex_rd = 5'd0; ex_we = 1'b0; ex_ld = 1'b0;
        ma_rd = 5'd9; ma_we = 1'b1;
        #1 check("R7 second cycle stall", {7'b0, stall}, 8'h00);
        check("R7 bubble select", {4'b0, fwd_sel}, 8'h00);
        @(posedge clk);
        #1 check("R7 select after hold", {4'b0, fwd_sel}, 8'h01);

        // R8 on operand B with a load writing r0
        @(negedge clk);
        drive('0);
        id_src = {5'd0, 5'd0}; id_use = 2'b10;
        ex_rd = 5'd0; ex_we = 1'b1; ex_ld = 1'b1;
        #1 check("R8 r0 load no stall", {7'b0, stall}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule